// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of an asynchronous serial port: a transmitter and a receiver that share one control word. The control word sets the frame format. Frames carry 5 to 8 data bits and one or two stop bits. Parity is optional and can be odd, even or held at a fixed level. Test controls can hold the line at the break level or corrupt the parity or stop bit of outgoing frames. A separate baud generator supplies a tick at the oversampling rate, and one bit lasts `OVS` ticks.

On the transmit side, software writes bytes into a single holding register. The byte moves to the shifter as soon as the shifter is free. On the receive side, each finished character goes into a buffer register, together with its error flags. One status byte reports the state of both directions. Reading the buffer clears the receive flags.

Top module: `uart_frame_engine`

## Requirements
- R1: Control bits 9:8 hold the data length minus 5. Data goes out LSB first. The received byte on `rx_data` is right-aligned, with its unused upper bits at zero.
- R2: Control bit 12 set sends two stop bits; clear sends one. The transmitter is fully idle (status bit 7) only after the last stop bit has ended.
- R3: Control bit 14 enables a parity bit after the data. Control bit 15 set gives even parity, so data plus parity has an even count of ones. Clear gives odd parity.
- R4: With control bit 16 set and parity enabled, the parity bit is fixed: 0 when bit 15 is set and 1 when it is clear.
- R5: While control bits 0 and 19 are both set, `txd` is low from the next cycle on.
- R6: Control bit 17 inverts the transmitted parity bit. A receiver with the same format reports a parity error in status bit 2.
- R7: Control bit 18 sends every stop bit low. The receiver reports a framing error in status bit 3.
- R8: A frame that stays low from the start bit through the first stop bit sets break (status bit 4). It gives a zero byte and clears both the framing and parity error flags.
- R9: When a character completes while data ready (status bit 0) is still set, overrun (status bit 1) is set. The buffered byte is kept and the new one is discarded.
- R10: Status bit 5 is set while the holding register is empty. It clears from a write until the byte moves to the shifter.
- R11: While control bit 0 is clear, `txd` stays high and a written byte waits in the holding register. Line activity on `rxd` produces no character.
- R12: A pulse on `rx_rd_en` clears status bits 4:0.
- R13: A frame starts with a low start bit, and each bit lasts `OVS` baud ticks. An idle line is high. Status bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Frame format, enable, break and error-injection controls |
| baud_tick | input | 1 | Oversampling tick from the baud generator |
| tx_wr_en | input | 1 | Writes `tx_wr_data` into the holding register when it is empty |
| tx_wr_data | input | 8 | Byte to transmit |
| rx_rd_en | input | 1 | Read strobe for the receive buffer; clears the receive flags |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_data | output | 8 | Receive buffer register |
| line_status | output | 8 | Status: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 holding empty, 7 idle |

## Verification
The assertions assume that `ctrl_word` stays fixed while a frame is in flight. They also assume that a read strobe means software has consumed the buffer. Under those assumptions, data ready can fall only after a read, and break can only appear with a zero byte. The stimulus changes the control word only between frames, once the monitor has seen the final stop bit. It loops `txd` back to `rxd`, except in the one directed step that drives the receive line itself while the block is disabled. The random frame formats, data and injected errors all come from one fixed seed.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  localparam int CB_EN       = 0;
  localparam int CB_WLS_LO   = 8;
  localparam int CB_TWO_STOP = 12;
  localparam int CB_PAR_EN   = 14;
  localparam int CB_PAR_EVEN = 15;
  localparam int CB_STICK    = 16;
  localparam int CB_FORCE_PE = 17;
  localparam int CB_FORCE_FE = 18;
  localparam int CB_BREAK    = 19;

  typedef struct packed {
    logic       en;
    logic [1:0] wls;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       force_pe;
    logic       force_fe;
    logic       brk;
  } fmt_t;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP, FS_HOLD
  } frame_st_t;

  function automatic fmt_t decode_ctrl(input logic [31:0] c);
    fmt_t f;
    f.en        = c[CB_EN];
    f.wls       = c[CB_WLS_LO+1:CB_WLS_LO];
    f.two_stop  = c[CB_TWO_STOP];
    f.par_en    = c[CB_PAR_EN];
    f.par_even  = c[CB_PAR_EVEN];
    f.par_stick = c[CB_STICK];
    f.force_pe  = c[CB_FORCE_PE];
    f.force_fe  = c[CB_FORCE_FE];
    f.brk       = c[CB_BREAK];
    return f;
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] wls);
    return 8'hFF >> (2'd3 - wls);
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] wls,
                                      input logic even, input logic stick);
    logic [7:0] m;
    m = d & len_mask(wls);
    if (stick) return ~even;
    return even ? ^m : ~^m;
  endfunction

endpackage

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uart_frame_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] wls,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       force_pe,
  input  logic       force_fe,
  input  logic       brk,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       thre,
  output logic       temt
);

  localparam int OS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVS - 1);

  frame_st_t       st_q, st_d;
  logic [OS_W-1:0] os_q, os_d;
  logic [2:0]      bit_q, bit_d;
  logic            stop2_q, stop2_d;
  logic [7:0]      hold_q, hold_d;
  logic            full_q, full_d;
  logic [7:0]      sh_q, sh_d;
  logic            par_q, par_d;
  logic            txd_q, txd_d;
  logic            bit_end;
  logic [2:0]      last_idx;

  assign bit_end  = tick && (os_q == OS_LAST);
  assign last_idx = {1'b0, wls} + 3'd4;

  always_comb begin
    st_d    = st_q;
    os_d    = os_q;
    bit_d   = bit_q;
    stop2_d = stop2_q;
    hold_d  = hold_q;
    full_d  = full_q;
    sh_d    = sh_q;
    par_d   = par_q;

    if (!en) begin
      st_d = FS_IDLE;
      os_d = '0;
    end else if (st_q == FS_IDLE) begin
      if (tick && full_q) begin
        st_d   = FS_START;
        os_d   = '0;
        sh_d   = hold_q;
        par_d  = parity_bit(hold_q, wls, par_even, par_stick);
        full_d = 1'b0;
      end
    end else if (tick) begin
      os_d = bit_end ? '0 : os_q + 1'b1;
      if (bit_end) begin
        unique case (st_q)
          FS_START: begin
            st_d  = FS_DATA;
            bit_d = '0;
          end
          FS_DATA: begin
            sh_d  = sh_q >> 1;
            bit_d = bit_q + 1'b1;
            if (bit_q == last_idx) begin
              st_d    = par_en ? FS_PAR : FS_STOP;
              stop2_d = 1'b0;
            end
          end
          FS_PAR: begin
            st_d    = FS_STOP;
            stop2_d = 1'b0;
          end
          FS_STOP: begin
            if (two_stop && !stop2_q) stop2_d = 1'b1;
            else                      st_d    = FS_IDLE;
          end
          default: st_d = FS_IDLE;
        endcase
      end
    end

    if (wr_en && !full_q) begin
      hold_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_comb begin
    if (!en)     txd_d = 1'b1;
    else if (brk) txd_d = 1'b0;
    else begin
      unique case (st_d)
        FS_START: txd_d = 1'b0;
        FS_DATA:  txd_d = sh_d[0];
        FS_PAR:   txd_d = par_d ^ force_pe;
        FS_STOP:  txd_d = ~force_fe;
        default:  txd_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      stop2_q <= 1'b0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      os_q    <= os_d;
      bit_q   <= bit_d;
      stop2_q <= stop2_d;
      hold_q  <= hold_d;
      full_q  <= full_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      txd_q   <= txd_d;
    end
  end

  assign txd  = txd_q;
  assign thre = ~full_q;
  assign temt = ~full_q && (st_q == FS_IDLE);

endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
  import uart_frame_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] wls,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       tick,
  input  logic       rxd,
  input  logic       rd_en,
  output logic [7:0] rx_data,
  output logic       dr,
  output logic       oe,
  output logic       pe,
  output logic       fe,
  output logic       bi
);

  localparam int OS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVS - 1);
  localparam logic [OS_W-1:0] OS_HALF = OS_W'(OVS / 2 - 1);

  logic            s1_q, s2_q;
  frame_st_t       st_q, st_d;
  logic [OS_W-1:0] os_q, os_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic            par_q, par_d;
  logic            zero_q, zero_d;
  logic            done;
  logic [7:0]      buf_q, buf_d;
  logic            dr_q, dr_d, oe_q, oe_d, pe_q, pe_d, fe_q, fe_d, bi_q, bi_d;
  logic            is_brk, is_pe, is_fe;
  logic [7:0]      aligned;
  logic [2:0]      last_idx;
  logic            samp;

  assign last_idx = {1'b0, wls} + 3'd4;
  assign samp     = tick && (os_q == OS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    st_d   = st_q;
    os_d   = os_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    zero_d = zero_q;
    done   = 1'b0;

    if (!en) begin
      st_d = FS_IDLE;
      os_d = '0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (tick && !s2_q) begin
            st_d = FS_START;
            os_d = '0;
          end
        end
        FS_START: begin
          if (tick) begin
            os_d = os_q + 1'b1;
            if (os_q == OS_HALF) begin
              os_d = '0;
              if (!s2_q) begin
                st_d   = FS_DATA;
                bit_d  = '0;
                sh_d   = '0;
                zero_d = 1'b1;
              end else begin
                st_d = FS_IDLE;
              end
            end
          end
        end
        FS_DATA, FS_PAR, FS_STOP: begin
          if (tick) os_d = samp ? '0 : os_q + 1'b1;
          if (samp) begin
            if (st_q == FS_DATA) begin
              sh_d   = {s2_q, sh_q[7:1]};
              zero_d = zero_q & ~s2_q;
              bit_d  = bit_q + 1'b1;
              if (bit_q == last_idx) st_d = par_en ? FS_PAR : FS_STOP;
            end else if (st_q == FS_PAR) begin
              par_d  = s2_q;
              zero_d = zero_q & ~s2_q;
              st_d   = FS_STOP;
            end else begin
              done = 1'b1;
              st_d = s2_q ? FS_IDLE : FS_HOLD;
            end
          end
        end
        FS_HOLD: begin
          if (s2_q) st_d = FS_IDLE;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_comb begin
    is_brk  = zero_q && !s2_q;
    aligned = is_brk ? 8'h00 : (sh_q >> (2'd3 - wls));
    is_fe   = !s2_q && !is_brk;
    is_pe   = par_en && !is_brk &&
              (par_q != parity_bit(aligned, wls, par_even, par_stick));

    buf_d = buf_q;
    dr_d  = dr_q;
    oe_d  = oe_q;
    pe_d  = pe_q;
    fe_d  = fe_q;
    bi_d  = bi_q;
    if (done && dr_q && !rd_en) begin
      oe_d = 1'b1;
    end else if (done) begin
      buf_d = aligned;
      dr_d  = 1'b1;
      oe_d  = 1'b0;
      pe_d  = is_pe;
      fe_d  = is_fe;
      bi_d  = is_brk;
    end else if (rd_en) begin
      dr_d = 1'b0;
      oe_d = 1'b0;
      pe_d = 1'b0;
      fe_d = 1'b0;
      bi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      os_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
      buf_q  <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      zero_q <= zero_d;
      buf_q  <= buf_d;
      dr_q   <= dr_d;
      oe_q   <= oe_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      bi_q   <= bi_d;
    end
  end

  assign rx_data = buf_q;
  assign dr      = dr_q;
  assign oe      = oe_q;
  assign pe      = pe_q;
  assign fe      = fe_q;
  assign bi      = bi_q;

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_frame_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  input  logic        baud_tick,
  input  logic        tx_wr_en,
  input  logic [7:0]  tx_wr_data,
  input  logic        rx_rd_en,
  input  logic        rxd,
  output logic        txd,
  output logic [7:0]  rx_data,
  output logic [7:0]  line_status
);

  fmt_t cfg;
  logic thre, temt, dr, oe, pe, fe, bi;

  assign cfg = decode_ctrl(ctrl_word);

  uart_fmt_tx #(.OVS(OVS)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .wls       (cfg.wls),
    .two_stop  (cfg.two_stop),
    .par_en    (cfg.par_en),
    .par_even  (cfg.par_even),
    .par_stick (cfg.par_stick),
    .force_pe  (cfg.force_pe),
    .force_fe  (cfg.force_fe),
    .brk       (cfg.brk),
    .tick      (baud_tick),
    .wr_en     (tx_wr_en),
    .wr_data   (tx_wr_data),
    .txd       (txd),
    .thre      (thre),
    .temt      (temt)
  );

  uart_fmt_rx #(.OVS(OVS)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .wls       (cfg.wls),
    .par_en    (cfg.par_en),
    .par_even  (cfg.par_even),
    .par_stick (cfg.par_stick),
    .tick      (baud_tick),
    .rxd       (rxd),
    .rd_en     (rx_rd_en),
    .rx_data   (rx_data),
    .dr        (dr),
    .oe        (oe),
    .pe        (pe),
    .fe        (fe),
    .bi        (bi)
  );

  assign line_status = {temt, 1'b0, thre, bi, fe, pe, oe, dr};

endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic        tx_wr_en,
  input logic        rx_rd_en,
  input logic        txd,
  input logic [7:0]  rx_data,
  input logic [7:0]  line_status
);

  // R5: break level follows one cycle after break request
  p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[0] && ctrl_word[19]) |=> !txd);

  // R11: disabled transmitter keeps the line high
  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[0] |=> txd);

  // R12: data ready only drops after a read
  p_dr_fall_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_status[0]) |-> $past(rx_rd_en));

  // R8: break carries a zero byte and no framing error
  p_break_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[4] |-> (rx_data == 8'h00 && !line_status[3]));

  // R9: overrun only while a character is held
  p_overrun_with_dr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[1] |-> line_status[0]);

  // R10: holding register fills only on a write
  p_thre_fall_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_status[5]) |-> $past(tx_wr_en));

  // R2: fully idle implies holding register empty
  p_temt_implies_thre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[7] |-> line_status[5]);

  // R13: reserved status bit
  p_reserved_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !line_status[6]);

endmodule

bind uart_frame_engine uart_frame_engine_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_word   (ctrl_word),
  .tx_wr_en    (tx_wr_en),
  .rx_rd_en    (rx_rd_en),
  .txd         (txd),
  .rx_data     (rx_data),
  .line_status (line_status)
);

// File: tb/uart_frame_engine_tb.sv
module uart_frame_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int BIT_CYC    = OVS * 2;

  logic        clk;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic        baud_tick;
  logic        tx_wr_en;
  logic [7:0]  tx_wr_data;
  logic        rx_rd_en;
  logic        rxd;
  logic        txd;
  logic [7:0]  rx_data;
  logic [7:0]  line_status;
  logic        inj_en;
  logic        inj_rxd;

  int checks;
  int failures;
  bit finished;

  assign rxd = inj_en ? inj_rxd : txd;

  uart_frame_engine #(.OVS(OVS)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_word   (ctrl_word),
    .baud_tick   (baud_tick),
    .tx_wr_en    (tx_wr_en),
    .tx_wr_data  (tx_wr_data),
    .rx_rd_en    (rx_rd_en),
    .rxd         (rxd),
    .txd         (txd),
    .rx_data     (rx_data),
    .line_status (line_status)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= ~baud_tick;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input int wl, input bit two,
      input bit pen, input bit even, input bit stick, input bit fpe, input bit ffe,
      input bit brk);
    logic [31:0] c;
    c = '0;
    c[0] = en;
    c[9:8] = 2'(wl - 5);
    c[12] = two;
    c[14] = pen;
    c[15] = even;
    c[16] = stick;
    c[17] = fpe;
    c[18] = ffe;
    c[19] = brk;
    return c;
  endfunction

  function automatic logic [7:0] mask_of(input logic [31:0] c);
    return 8'hFF >> (3 - int'(c[9:8]));
  endfunction

  function automatic logic exp_par(input logic [31:0] c, input logic [7:0] d);
    logic [7:0] m;
    m = d & mask_of(c);
    if (c[16]) return ~c[15];
    return c[15] ? ($countones(m) % 2 == 1) : ($countones(m) % 2 == 0);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    tx_wr_data = d;
    tx_wr_en   = 1'b1;
    @(negedge clk);
    tx_wr_en   = 1'b0;
  endtask

  task automatic read_buf();
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  // Watches one frame on txd and compares each bit with the format.
  task automatic watch_tx(input logic [31:0] c, input logic [7:0] d, input bit idle_chk);
    int   nb;
    int   wait_n;
    logic pb;
    nb = int'(c[9:8]) + 5;
    wait_n = 0;
    while (txd !== 1'b0 && wait_n < 4000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(wait_n < 4000, "R13 frame start seen", 32'(wait_n), 32'd0);
    cyc(BIT_CYC / 2);
    chk(txd == 1'b0, "R13 start bit low", 32'(txd), 32'd0);
    for (int i = 0; i < nb; i++) begin
      cyc(BIT_CYC);
      chk(txd == d[i], "R1 data bit", 32'(txd), 32'(d[i]));
    end
    if (c[14]) begin
      pb = exp_par(c, d) ^ c[17];
      cyc(BIT_CYC);
      chk(txd == pb, "R3 R4 R6 parity bit", 32'(txd), 32'(pb));
    end
    cyc(BIT_CYC);
    chk(txd == !c[18], "R7 stop bit level", 32'(txd), 32'(!c[18]));
    if (c[12]) begin
      chk(line_status[7] == 1'b0, "R2 busy during first stop", 32'(line_status[7]), 32'd0);
      cyc(BIT_CYC);
      chk(txd == !c[18], "R2 second stop bit", 32'(txd), 32'(!c[18]));
    end
    if (idle_chk) begin
      cyc(BIT_CYC * 3 / 4);
      chk(line_status[7] == 1'b1, "R2 idle after last stop", 32'(line_status[7]), 32'd1);
      chk(line_status[5] == 1'b1, "R10 holding empty when idle", 32'(line_status[5]), 32'd1);
    end
  endtask

  // Compares the receive buffer with what the frame should yield.
  task automatic check_rx(input logic [31:0] c, input logic [7:0] d);
    logic [7:0] m;
    bit         brk, fe, pe;
    logic       pb;
    m  = d & mask_of(c);
    pb = exp_par(c, d) ^ c[17];
    brk = (m == 8'h00) && (!c[14] || pb == 1'b0) && c[18];
    fe  = c[18] && !brk;
    pe  = c[14] && c[17] && !brk;
    chk(line_status[0] == 1'b1, "R1 data ready", 32'(line_status[0]), 32'd1);
    chk(rx_data == (brk ? 8'h00 : m), "R1 received byte", 32'(rx_data), 32'(brk ? 8'h00 : m));
    chk(line_status[2] == pe, "R6 parity error flag", 32'(line_status[2]), 32'(pe));
    chk(line_status[3] == fe, "R7 framing error flag", 32'(line_status[3]), 32'(fe));
    chk(line_status[4] == brk, "R8 break flag", 32'(line_status[4]), 32'(brk));
    chk(line_status[1] == 1'b0, "R9 no overrun", 32'(line_status[1]), 32'd0);
    read_buf();
    chk(line_status[4:0] == 5'b0, "R12 flags cleared by read", 32'(line_status[4:0]), 32'd0);
  endtask

  task automatic frame(input logic [31:0] c, input logic [7:0] d);
    ctrl_word = c;
    cyc(2);
    write_byte(d);
    watch_tx(c, d, 1'b1);
    check_rx(c, d);
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    finished   = 0;
    rst_n      = 1'b0;
    ctrl_word  = '0;
    tx_wr_en   = 1'b0;
    tx_wr_data = '0;
    rx_rd_en   = 1'b0;
    inj_en     = 1'b0;
    inj_rxd    = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);

    // Reset state
    chk(txd == 1'b1, "R13 idle line after reset", 32'(txd), 32'd1);
    chk(line_status == 8'hA0, "R10 reset status", 32'(line_status), 32'hA0);

    // R11: disabled block
    begin
      int lows;
      lows = 0;
      write_byte(8'h5A);
      inj_en  = 1'b1;
      inj_rxd = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (txd == 1'b0) lows++;
      end
      inj_rxd = 1'b1;
      cyc(4);
      inj_en = 1'b0;
      chk(lows == 0, "R11 no transmission while disabled", 32'(lows), 32'd0);
      chk(line_status[5] == 1'b0, "R11 byte waits in holding register",
          32'(line_status[5]), 32'd0);
      chk(line_status[0] == 1'b0, "R11 no character received while disabled",
          32'(line_status[0]), 32'd0);
      ctrl_word = mk_ctrl(1, 8, 0, 0, 0, 0, 0, 0, 0);
      watch_tx(ctrl_word, 8'h5A, 1'b1);
      check_rx(ctrl_word, 8'h5A);
    end

    // Directed formats
    frame(mk_ctrl(1, 8, 0, 1, 1, 1, 0, 0, 0), 8'hFF);  // R4 stick, even select
    frame(mk_ctrl(1, 5, 1, 1, 0, 1, 0, 0, 0), 8'h00);  // R4 stick, odd select
    frame(mk_ctrl(1, 7, 0, 1, 1, 0, 0, 0, 0), 8'h83);  // R3 even, upper bit dropped
    frame(mk_ctrl(1, 6, 1, 1, 0, 0, 1, 0, 0), 8'h2D);  // R6 forced parity
    frame(mk_ctrl(1, 8, 0, 0, 0, 0, 0, 1, 0), 8'hC3);  // R7 forced framing
    frame(mk_ctrl(1, 8, 1, 0, 0, 0, 0, 1, 0), 8'h00);  // R8 all-low frame

    // R9 / R10: back-to-back bytes, second completes over an unread first
    begin
      logic [31:0] c;
      c = mk_ctrl(1, 8, 0, 1, 0, 0, 0, 0, 0);
      ctrl_word = c;
      cyc(2);
      write_byte(8'h11);
      cyc(4);
      write_byte(8'h22);
      cyc(2);
      chk(line_status[5] == 1'b0, "R10 holding full after write", 32'(line_status[5]), 32'd0);
      chk(line_status[7] == 1'b0, "R10 not idle while busy", 32'(line_status[7]), 32'd0);
      watch_tx(c, 8'h11, 1'b0);
      watch_tx(c, 8'h22, 1'b1);
      chk(line_status[1:0] == 2'b11, "R9 overrun set", 32'(line_status[1:0]), 32'd3);
      chk(rx_data == 8'h11, "R9 first byte kept", 32'(rx_data), 32'h11);
      read_buf();
      chk(line_status[4:0] == 5'b0, "R12 read clears overrun", 32'(line_status[4:0]), 32'd0);
    end

    // R5 / R8: break generation and detection
    begin
      logic [31:0] c;
      c = mk_ctrl(1, 8, 0, 1, 1, 0, 0, 0, 0);
      ctrl_word = c | (32'd1 << 19);
      cyc(2);
      chk(txd == 1'b0, "R5 break drives line low", 32'(txd), 32'd0);
      cyc(BIT_CYC * 14);
      chk(txd == 1'b0, "R5 break held", 32'(txd), 32'd0);
      ctrl_word = c;
      cyc(BIT_CYC * 2);
      chk(line_status[4:0] == 5'b10001, "R8 break reported", 32'(line_status[4:0]), 32'h11);
      chk(rx_data == 8'h00, "R8 break byte zero", 32'(rx_data), 32'd0);
      read_buf();
    end

    // Random formats with a fixed seed
    begin
      int unused_seed;
      unused_seed = $urandom(32'h1F2E3D4C);
    end
    for (int n = 0; n < 24; n++) begin
      int wl;
      bit two, pen, even, stick, fpe, ffe;
      logic [7:0] d;
      wl    = 5 + int'($urandom % 4);
      two   = 1'($urandom);
      pen   = 1'($urandom);
      even  = 1'($urandom);
      stick = ($urandom % 4) == 0;
      fpe   = ($urandom % 6) == 0;
      ffe   = ($urandom % 8) == 0;
      d     = 8'($urandom);
      frame(mk_ctrl(1, wl, two, pen, even, stick, fpe, ffe, 0), d);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule